// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters over a single asynchronous serial line. A one-character holding buffer sits in front of a frame shift register. Software can therefore write the next character while the current one is still on the wire. When the transmitter is switched on, the block first sends a run of idle ones. It then sends each buffered character as a frame: a low start bit, the data bits with the least significant bit first, an optional parity bit that replaces the top data bit, and a high stop bit. Characters are 8 or 9 bits wide.

Bit timing comes from a 16-bit divisor, which is loaded a byte at a time. Each bit lasts sixteen sub-bit ticks, and each tick lasts divisor system clocks. A character waiting in the buffer is moved into the shift register nine ticks after its predecessor's stop bit begins. At that point the buffer-empty flag rises and, if enabled, raises an interrupt request. A completion flag tells software that the line has gone quiet with nothing left to send.

Top module: `sertx`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `tx_done` is 1 and `irq` equals `irq_en`.
- R2: When `tx_en` goes from 0 to 1, the line carries an all-ones preamble before any frame: 10 bit times when `word9` is 0 and 11 bit times when `word9` is 1.
- R3: A frame is a 0 start bit, then the data bits least significant bit first, then a 1 stop bit. With `word9`=0 the data bits are `data_lo[7:0]`.
- R4: With `par_en`=1 the top data bit (bit 7, or bit 8 with `word9`=1) is replaced by parity computed over the lower data bits. With `par_odd`=0 it is their XOR (even parity); with `par_odd`=1 it is the inverse (odd parity).
- R5: With `word9`=1 the frame carries 9 data bits, and the ninth bit is `data_b8`. With `word9`=0, `data_b8` has no effect.
- R6: While a frame is being sent and the buffer holds a character, the buffer is taken, and `buf_empty` rises, 9 ticks (9 × divisor clocks) after the stop bit starts. The next start bit follows directly when the stop bit ends.
- R7: `irq` is 1 exactly when `buf_empty` and `irq_en` are both 1.
- R8: With nothing being sent, `txd` is 1. One clock after `tx_en` is 0, `txd` is 1, even in the middle of a frame.
- R9: A divisor of zero stops all bit timing. A write to the high divisor byte is held and takes effect only together with the next low-byte write.
- R10: `tx_done` is set when a frame or the preamble ends with the buffer empty. It is cleared by a data write and stays 0 while back-to-back frames run.
- R11: A data write sets `buf_empty` to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; a rising edge starts the preamble |
| word9 | input | 1 | 1 selects 9-bit characters |
| par_en | input | 1 | 1 replaces the top data bit with parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| irq_en | input | 1 | Interrupt enable for buffer-empty |
| div_hi_we | input | 1 | Stage the high divisor byte from `div_byte` |
| div_lo_we | input | 1 | Load the divisor as {staged high byte, `div_byte`} |
| div_byte | input | DIV_W/2 | Divisor byte data |
| data_we | input | 1 | Write a character into the buffer |
| data_lo | input | 8 | Character bits 7..0 |
| data_b8 | input | 1 | Character bit 8 (9-bit mode) |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Buffer can take a character |
| tx_done | output | 1 | Line quiet with nothing pending |
| irq | output | 1 | Transmit interrupt request |

## Verification
Several properties are checked on every clock by assertions. The line goes high one clock after the enable drops. A zero divisor yields no ticks, and the divisor holds between low-byte writes. The buffer is only taken while it holds data. A data write fills the buffer and clears the completion flag. A start bit follows an idle-state load. Other behaviour can only be shown by the bench's scenarios. These are the preamble length in both word sizes, the bit order and parity value of each frame, and the exact handoff point inside the stop bit with the back-to-back frame that follows it. The stalled divisor and the staging of the high divisor byte are also shown by scenario.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int FRAME_W = 11;
  localparam int LEN_W   = 4;
  localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(10);
  localparam logic [LEN_W-1:0] LEN_WIDE = LEN_W'(11);
  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hi_we,
  input  logic               lo_we,
  input  logic [DIV_W/2-1:0] wbyte,
  output logic               tick
);
  localparam int HALF = DIV_W / 2;

  logic [HALF-1:0]  hi_stage;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage <= '0;
      div_q    <= '0;
      cnt      <= '0;
      tick     <= 1'b0;
    end else begin
      if (hi_we) hi_stage <= wbyte;
      if (lo_we) div_q <= {hi_stage, wbyte};
      if (div_q == '0) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (cnt >= div_q - DIV_W'(1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + DIV_W'(1);
        tick <= 1'b0;
      end
    end
  end

  // R9: zero divisor produces no tick
  a_r9_halt: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |=> !tick);
  // R9: divisor changes only on a low-byte write
  a_r9_stage: assert property (@(posedge clk) disable iff (rst)
    !lo_we |=> $stable(div_q));
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  logic             [8:0] data,
  input  logic                   wide,
  input  logic                   par_en,
  input  logic                   par_odd,
  output frame_t                 frame,
  output logic [LEN_W-1:0]       len
);
  logic top_bit;

  always_comb begin
    if (wide) begin
      top_bit = par_en ? ((^data[7:0]) ^ par_odd) : data[8];
      frame   = {1'b1, top_bit, data[7:0], 1'b0};
      len     = LEN_WIDE;
    end else begin
      top_bit = par_en ? ((^data[6:0]) ^ par_odd) : data[7];
      frame   = {2'b11, top_bit, data[6:0], 1'b0};
      len     = LEN_BYTE;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int HAND = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_pre,
  input  logic             tick,
  input  logic             have_data,
  input  frame_t           frame,
  input  logic [LEN_W-1:0] len,
  output logic             txd,
  output logic             take,
  output logic             fin
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_HAND = SUB_W'(HAND - 1);

  logic             busy;
  logic [SUB_W-1:0] sub;
  logic [LEN_W-1:0] rem;
  frame_t           sr;
  logic             at_hand;

  assign at_hand = busy && tick && (sub == SUB_HAND) && (rem == '0);
  assign take    = en && !start_pre && have_data && (!busy || at_hand);
  assign fin     = en && !start_pre && busy && tick && (sub == SUB_LAST) && (rem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sub  <= '0;
      rem  <= '0;
      sr   <= '1;
      txd  <= 1'b1;
    end else if (!en) begin
      busy <= 1'b0;
      sub  <= '0;
      rem  <= '0;
      txd  <= 1'b1;
    end else if (start_pre) begin
      busy <= 1'b1;
      sub  <= '0;
      rem  <= len - LEN_W'(1);
      sr   <= '1;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (have_data) begin
        busy <= 1'b1;
        sub  <= '0;
        rem  <= len - LEN_W'(1);
        sr   <= {1'b1, frame[FRAME_W-1:1]};
        txd  <= frame[0];
      end
    end else if (tick) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (rem != '0) begin
          txd <= sr[0];
          sr  <= {1'b1, sr[FRAME_W-1:1]};
          rem <= rem - LEN_W'(1);
        end else begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end
      end else begin
        sub <= sub + SUB_W'(1);
        if (at_hand && have_data) begin
          sr  <= frame;
          rem <= len;
        end
      end
    end
  end

  // R8: line goes idle one clock after the enable is low
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);
  // R3: a load from idle puts the start bit on the line
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    (take && !busy) |=> !txd);
  // R2: bit counter never exceeds a frame
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (rst)
    rem <= LEN_W'(FRAME_W));
endmodule

// File: rtl/sertx.sv
module sertx
  import sertx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16,
  parameter int HAND  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_en,
  input  logic               word9,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               irq_en,
  input  logic               div_hi_we,
  input  logic               div_lo_we,
  input  logic [DIV_W/2-1:0] div_byte,
  input  logic               data_we,
  input  logic [7:0]         data_lo,
  input  logic               data_b8,
  output logic               txd,
  output logic               buf_empty,
  output logic               tx_done,
  output logic               irq
);
  logic             tick;
  logic             en_q;
  logic             start_pre;
  logic [8:0]       buf_q;
  frame_t           frame;
  logic [LEN_W-1:0] len;
  logic             take;
  logic             fin;

  assign start_pre = tx_en && !en_q;

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst   (rst),
    .hi_we (div_hi_we),
    .lo_we (div_lo_we),
    .wbyte (div_byte),
    .tick  (tick)
  );

  sertx_frame u_frame (
    .data    (buf_q),
    .wide    (word9),
    .par_en  (par_en),
    .par_odd (par_odd),
    .frame   (frame),
    .len     (len)
  );

  sertx_shift #(.OVS(OVS), .HAND(HAND)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .start_pre (start_pre),
    .tick      (tick),
    .have_data (!buf_empty),
    .frame     (frame),
    .len       (len),
    .txd       (txd),
    .take      (take),
    .fin       (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      buf_q     <= '0;
      buf_empty <= 1'b1;
      tx_done   <= 1'b1;
    end else begin
      en_q <= tx_en;
      if (take) buf_empty <= 1'b1;
      if (fin)  tx_done   <= buf_empty;
      if (data_we) begin
        buf_q     <= {data_b8, data_lo};
        buf_empty <= 1'b0;
        tx_done   <= 1'b0;
      end
    end
  end

  assign irq = buf_empty && irq_en;

  // R6: buffer is only taken while it holds a character
  a_r6_take_full: assert property (@(posedge clk) disable iff (rst)
    take |-> !buf_empty);
  // R11: a write fills the buffer
  a_r11_write_fills: assert property (@(posedge clk) disable iff (rst)
    data_we |=> !buf_empty);
  // R10: a write clears the completion flag
  a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
    data_we |=> !tx_done);
endmodule

// File: tb/sim_sertx.sv
module sim_sertx;
  localparam int DIV = 4;
  localparam int T   = 16 * DIV;
  localparam int NV  = 7;
  // {word9, par_en, par_odd, data[8:0], expected line bits in send order}
  localparam logic [22:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 9'h055, 2'b11, 8'h55, 1'b0},
    {1'b0, 1'b1, 1'b0, 9'h083, 2'b11, 8'h03, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h003, 2'b11, 8'h83, 1'b0},
    {1'b1, 1'b0, 1'b0, 9'h1A5, 1'b1, 9'h1A5, 1'b0},
    {1'b1, 1'b1, 1'b0, 9'h1F0, 1'b1, 9'h0F0, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h003, 1'b1, 9'h103, 1'b0},
    {1'b0, 1'b0, 1'b0, 9'h1FF, 2'b11, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, word9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b1;
  logic div_hi_we = 1'b0, div_lo_we = 1'b0;
  logic [7:0] div_byte = '0;
  logic data_we = 1'b0;
  logic [7:0] data_lo = '0;
  logic data_b8 = 1'b0;
  logic txd, buf_empty, tx_done, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sertx u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .word9(word9), .par_en(par_en),
    .par_odd(par_odd), .irq_en(irq_en), .div_hi_we(div_hi_we),
    .div_lo_we(div_lo_we), .div_byte(div_byte), .data_we(data_we),
    .data_lo(data_lo), .data_b8(data_b8), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_hi(input logic [7:0] b);
    @(negedge clk); div_hi_we = 1'b1; div_byte = b;
    @(negedge clk); div_hi_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] b);
    @(negedge clk); div_lo_we = 1'b1; div_byte = b;
    @(negedge clk); div_lo_we = 1'b0;
  endtask

  task automatic wr_data(input logic [8:0] d);
    @(negedge clk); data_we = 1'b1; data_lo = d[7:0]; data_b8 = d[8];
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (txd !== 1'b0 && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  // called at the negedge where the start bit is first seen
  task automatic sample_bits(input int len, output logic [10:0] bits);
    bits = '1;
    repeat (T / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bits[i] = txd;
      if (i < len - 1) repeat (T) @(negedge clk);
    end
  endtask

  task automatic run_vec(input logic [22:0] v, input string tag);
    int n;
    int len;
    logic [10:0] bits;
    logic [10:0] mask;
    @(negedge clk);
    tx_en = 1'b0; word9 = v[22]; par_en = v[21]; par_odd = v[20];
    len = v[22] ? 11 : 10;
    mask = v[22] ? 11'h7FF : 11'h3FF;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    n = 0;
    while (txd !== 1'b0 && n < 3000) begin
      @(negedge clk); n++;
      if (n == 2) begin data_we = 1'b1; data_lo = v[18:11]; data_b8 = v[19]; end
      if (n == 3) data_we = 1'b0;
    end
    // R2: preamble of len bit times
    chk(n >= len * T - 4 && n <= len * T + 2, {"R2 preamble ", tag}, n, len * T);
    sample_bits(len, bits);
    // R3 R4 R5: frame contents
    chk((bits & mask) == (v[10:0] & mask), {"R3 R4 R5 frame ", tag}, int'(bits & mask), int'(v[10:0] & mask));
    repeat (T) @(negedge clk);
    chk(tx_done === 1'b1, {"R10 done after frame ", tag}, tx_done, 1);
    chk(buf_empty === 1'b1, {"R6 empty after frame ", tag}, buf_empty, 1);
    tx_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [10:0] bits;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(buf_empty === 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(tx_done === 1'b1, "R1 tx_done", tx_done, 1);
    chk(irq === 1'b1, "R1 irq", irq, 1);

    wr_hi(8'h00);
    wr_lo(8'(DIV));

    // R11 R7 R10: write while disabled
    wr_data(9'h011);
    chk(buf_empty === 1'b0, "R11 write fills", buf_empty, 0);
    chk(irq === 1'b0, "R7 irq low when full", irq, 0);
    chk(tx_done === 1'b0, "R10 write clears done", tx_done, 0);
    repeat (200) @(negedge clk);
    chk(txd === 1'b1, "R8 idle while disabled", txd, 1);
    // drain it: enable, let it go out
    @(negedge clk); tx_en = 1'b1;
    repeat (22 * T) @(negedge clk);
    chk(irq === 1'b1, "R7 irq when empty", irq, 1);
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R7 irq masked", irq, 0);
    irq_en = 1'b1;
    tx_en = 1'b0;

    // table of frames
    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("v%0d", i));

    // R6 R10: handoff point and back-to-back frames
    @(negedge clk); word9 = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    wr_data(9'h00F);
    wait_fall(n);
    data_we = 1'b1; data_lo = 8'hC3; data_b8 = 1'b0;
    for (int m = 1; m <= 10 * T + T / 2; m++) begin
      @(negedge clk);
      if (m == 1) data_we = 1'b0;
      if (m == 9 * T + 9 * DIV - 4)
        chk(buf_empty === 1'b0, "R6 still full before handoff", buf_empty, 0);
      if (m == 9 * T + 9 * DIV + 4)
        chk(buf_empty === 1'b1, "R6 taken at 9 ticks into stop", buf_empty, 1);
      if (m == 9 * T + T / 2)
        chk(txd === 1'b1, "R3 stop bit high", txd, 1);
      if (m == 10 * T - 8)
        chk(tx_done === 1'b0, "R10 no done between frames", tx_done, 0);
      if (m == 10 * T + T / 2)
        chk(txd === 1'b0, "R6 next start follows stop", txd, 0);
    end
    repeat (10 * T) @(negedge clk);
    chk(tx_done === 1'b1, "R10 done after second frame", tx_done, 1);

    // R8: disable in the middle of a frame
    wr_data(9'h0AA);
    wait_fall(n);
    repeat (3 * T) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R8 forced idle on disable", txd, 1);
    repeat (T) @(negedge clk);
    chk(txd === 1'b1, "R8 stays idle", txd, 1);

    // R9: high byte staged only; rate must not change
    wr_hi(8'h01);
    run_vec(VEC[0], "staged-high");

    // R9: divisor zero halts everything
    wr_hi(8'h00);
    wr_lo(8'h00);
    @(negedge clk); word9 = 1'b0; par_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    wr_data(9'h03C);
    repeat (2000) @(negedge clk);
    chk(txd === 1'b1, "R9 line static at zero divisor", txd, 1);
    chk(buf_empty === 1'b0, "R9 no handoff at zero divisor", buf_empty, 0);
    wr_lo(8'(DIV));
    wait_fall(n);
    sample_bits(10, bits);
    chk(bits[9:0] === {1'b1, 8'h3C, 1'b0}, "R9 R3 frame after restart", int'(bits[9:0]), int'({1'b1, 8'h3C, 1'b0}));
    repeat (T) @(negedge clk);
    chk(tx_done === 1'b1, "R10 done after restart", tx_done, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule